// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers five interrupt request lines for a small 8-bit core and picks one to serve. The lines are a non-maskable emergency input (TRAP), three restart lines at levels 7.5, 6.5 and 5.5 that can each be masked, and a general request line (INTR). While any line is eligible the block raises a request towards the core. When the core acknowledges, the block registers the winner's fixed 16-bit service address. For INTR it instead flags that the requester must supply the target, and pulses an acknowledge strobe towards it.

Software controls the block through an enable/disable command pair and a mask write port. It observes the block through a status word. Accepting any maskable source turns the global enable off, so handlers run uninterrupted until software enables again. A separate combinational decoder turns a software restart number into its vector address.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the global enable is 0, all three restart masks are 1, no restart line is latched pending, `grant_vld` and `inta_o` are 0, and `grant_vec` is 0000H.
- R2: Among eligible sources the winner is always, from highest to lowest: TRAP, RST7.5, RST6.5, RST5.5, INTR. `irq_req` is high exactly when at least one source is eligible.
- R3: A granted TRAP yields vector 0024H, RST7.5 003CH, RST6.5 0034H and RST5.5 002CH.
- R4: TRAP is eligible regardless of the global enable and of every mask bit.
- R5: A pulse on `ie_clr` clears the global enable and a pulse on `ie_set` sets it. If both are high in the same cycle, clear wins. While the enable is 0, no source other than TRAP is eligible.
- R6: A write with `msk_wdata[3]`=1 loads the masks from `msk_wdata[2:0]` (bit0 RST5.5, bit1 RST6.5, bit2 RST7.5; 1 = masked). A write with bit3=0 leaves them unchanged. INTR is never masked by them.
- R7: An INTR grant sets `grant_ext`=1 and `grant_vec`=0000H, and raises `inta_o` for exactly the `grant_vld` cycle. Any other grant sets `grant_ext`=0 and leaves `inta_o` low.
- R8: `swi_vec` equals 8 × `swi_num` (0000H to 0038H) at all times.
- R9: Accepting RST7.5, RST6.5, RST5.5 or INTR clears the global enable. Accepting TRAP leaves it unchanged. An `ie_set` in the accepting cycle is lost.
- R10: RST7.5 latches on a rising edge and stays pending until it is granted, or until a mask write with `msk_wdata[4]`=1 clears it. RST6.5, RST5.5 and INTR follow their current level.
- R11: TRAP becomes pending only on a rising edge. It stays eligible only while the line is still high. After one grant, a line held high does not request again.
- R12: `status_o` bits [2:0] are the masks (as in R6), bit 3 the global enable, bit 4 the RST5.5 level, bit 5 the RST6.5 level and bit 6 the RST7.5 latch.
- R13: A grant is taken at a clock edge where `irq_ack` and `irq_req` are both high. `grant_vld` is high for the following cycle only. `irq_ack` without `irq_req` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Non-maskable request line |
| rst75_req | input | 1 | Edge-latched restart request, level 7.5 |
| rst65_req | input | 1 | Level restart request, level 6.5 |
| rst55_req | input | 1 | Level restart request, level 5.5 |
| intr_req | input | 1 | General request, externally vectored |
| ie_set | input | 1 | Global enable command |
| ie_clr | input | 1 | Global disable command |
| msk_wr | input | 1 | Mask write strobe |
| msk_wdata | input | 5 | [2:0] masks, [3] mask load enable, [4] clear RST7.5 latch |
| irq_ack | input | 1 | Core accepts the current request |
| irq_req | output | 1 | Some source is eligible |
| grant_vld | output | 1 | One-cycle grant pulse |
| grant_vec | output | 16 | Service address of last grant |
| grant_ext | output | 1 | Last grant needs an external vector |
| inta_o | output | 1 | Acknowledge strobe to the INTR requester |
| status_o | output | 7 | Masks, enable and pending restart lines |
| swi_num | input | 3 | Software restart number |
| swi_vec | output | 16 | Vector address of `swi_num` |

## Verification
The bench holds TRAP high for many acknowledged cycles. A design that re-arms on level would grant it repeatedly instead of once. A single-cycle RST7.5 pulse is acknowledged long after it ends, which catches a design that treats that line as level-sensitive and loses the request. The bench drives enable and disable together, and enable in the same cycle as a maskable grant; a wrong ordering would leave handlers open to nesting. Random traffic with every mask pattern checks that the priority order and the unmasked status of INTR hold.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, source encoding and the fixed vector table.
// Assumes source index 0 is the highest priority.
package vic_pkg;
    localparam int VEC_W   = 16;
    localparam int N_SRC   = 5;
    localparam int SRC_W   = $clog2(N_SRC);
    localparam int N_MSK   = 3;
    localparam int MW_EN   = 3;              // mask load enable bit
    localparam int MW_CLR  = 4;              // RST7.5 latch clear bit
    localparam int MW_W    = 5;
    localparam int STAT_W  = 7;
    localparam int SWI_W   = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_TRAP = 3'd0,
        SRC_R75  = 3'd1,
        SRC_R65  = 3'd2,
        SRC_R55  = 3'd3,
        SRC_INTR = 3'd4
    } src_e;

    // Fixed service address per source; INTR has none.
    function automatic logic [VEC_W-1:0] fixed_vec(src_e s);
        case (s)
            SRC_TRAP: fixed_vec = VEC_W'(16'h0024);
            SRC_R75:  fixed_vec = VEC_W'(16'h003C);
            SRC_R65:  fixed_vec = VEC_W'(16'h0034);
            SRC_R55:  fixed_vec = VEC_W'(16'h002C);
            default:  fixed_vec = '0;
        endcase
    endfunction
endpackage

// File: rtl/vic_edge_pend.sv
`timescale 1ns/1ps
// Rising-edge request latch.
// HOLD_LEVEL=1: pending drops as soon as the line goes low (edge-and-level).
// HOLD_LEVEL=0: pending holds until clr_i.
// Assumes req_i is already synchronous to clk. Clear takes precedence over set.
module vic_edge_pend #(
    parameter bit HOLD_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic clr_i,
    output logic pend_o
);
    logic req_d;
    logic drop;

    // Previous line level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_d <= 1'b0;
        else        req_d <= req_i;
    end

    // Select the drop condition for the chosen variant.
    generate
        if (HOLD_LEVEL) begin : g_lvl
            assign drop = clr_i | ~req_i;
        end else begin : g_edge
            assign drop = clr_i;
        end
    endgenerate

    // Pending flag: clear wins, otherwise set on a rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_o <= 1'b0;
        else if (drop)             pend_o <= 1'b0;
        else if (req_i && !req_d)  pend_o <= 1'b1;
    end
endmodule

// File: rtl/vic_ctl_regs.sv
`timescale 1ns/1ps
// Global enable and restart mask registers.
// Assumes one-cycle command strobes. An acceptance clear beats ie_clr, which beats ie_set.
module vic_ctl_regs
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ie_set,
    input  logic             ie_clr,
    input  logic             acc_clr,
    input  logic             msk_wr,
    input  logic [MW_W-1:0]  msk_wdata,
    output logic             ie_o,
    output logic [N_MSK-1:0] msk_o
);
    // Global enable update by priority of its three causes.
    always_ff @(posedge clk) begin
        if (!rst_n)       ie_o <= 1'b0;
        else if (acc_clr) ie_o <= 1'b0;
        else if (ie_clr)  ie_o <= 1'b0;
        else if (ie_set)  ie_o <= 1'b1;
    end

    // Mask load, gated by the write's enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                          msk_o <= '1;
        else if (msk_wr && msk_wdata[MW_EN]) msk_o <= msk_wdata[N_MSK-1:0];
    end
endmodule

// File: rtl/vic_prio.sv
`timescale 1ns/1ps
// Fixed-priority picker: lowest set index wins.
// Assumes index 0 is the highest priority.
module vic_prio #(
    parameter int N   = 5,
    parameter int IDX = $clog2(N)
) (
    input  logic [N-1:0]   req_i,
    output logic           any_o,
    output logic [IDX-1:0] win_o
);
    // Scan from lowest to highest priority so the highest one overwrites.
    always_comb begin
        any_o = 1'b0;
        win_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                win_o = IDX'(i);
            end
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
`timescale 1ns/1ps
// Prioritized vectored interrupt controller, top level.
// Qualifies five request lines with enable and masks, picks a winner, and registers
// its vector when the core acknowledges. Also decodes software restart vectors.
// Assumes all request inputs are synchronous to clk.
module vec_irq_ctrl
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic              rst75_req,
    input  logic              rst65_req,
    input  logic              rst55_req,
    input  logic              intr_req,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              msk_wr,
    input  logic [MW_W-1:0]   msk_wdata,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic              grant_vld,
    output logic [VEC_W-1:0]  grant_vec,
    output logic              grant_ext,
    output logic              inta_o,
    output logic [STAT_W-1:0] status_o,
    input  logic [SWI_W-1:0]  swi_num,
    output logic [VEC_W-1:0]  swi_vec
);
    logic             ie;
    logic [N_MSK-1:0] msk;
    logic             trap_pend, r75_pend;
    logic [N_SRC-1:0] elig;
    logic             any;
    logic [SRC_W-1:0] win;
    src_e             win_s;
    logic             accept;

    assign win_s  = src_e'(win);
    assign accept = irq_ack & any;

    vic_edge_pend #(.HOLD_LEVEL(1'b1)) u_trap (
        .clk(clk), .rst_n(rst_n), .req_i(trap_req),
        .clr_i(accept && win_s == SRC_TRAP), .pend_o(trap_pend)
    );

    vic_edge_pend #(.HOLD_LEVEL(1'b0)) u_r75 (
        .clk(clk), .rst_n(rst_n), .req_i(rst75_req),
        .clr_i((accept && win_s == SRC_R75) || (msk_wr && msk_wdata[MW_CLR])),
        .pend_o(r75_pend)
    );

    vic_ctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ie_set(ie_set), .ie_clr(ie_clr),
        .acc_clr(accept && win_s != SRC_TRAP),
        .msk_wr(msk_wr), .msk_wdata(msk_wdata), .ie_o(ie), .msk_o(msk)
    );

    // Qualify each source with its enable and mask.
    always_comb begin
        elig           = '0;
        elig[SRC_TRAP] = trap_pend & trap_req;
        elig[SRC_R75]  = ie & ~msk[2] & r75_pend;
        elig[SRC_R65]  = ie & ~msk[1] & rst65_req;
        elig[SRC_R55]  = ie & ~msk[0] & rst55_req;
        elig[SRC_INTR] = ie & intr_req;
    end

    vic_prio #(.N(N_SRC)) u_prio (.req_i(elig), .any_o(any), .win_o(win));

    assign irq_req = any;

    // Grant pulse and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_vld <= 1'b0;
            inta_o    <= 1'b0;
        end else begin
            grant_vld <= accept;
            inta_o    <= accept && win_s == SRC_INTR;
        end
    end

    // Vector and external flag, held between grants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_vec <= '0;
            grant_ext <= 1'b0;
        end else if (accept) begin
            grant_vec <= fixed_vec(win_s);
            grant_ext <= (win_s == SRC_INTR);
        end
    end

    assign status_o = {r75_pend, rst65_req, rst55_req, ie, msk};
    assign swi_vec  = {{(VEC_W-SWI_W-3){1'b0}}, swi_num, 3'b000};
endmodule

// File: rtl/vic_chk.sv
`timescale 1ns/1ps
// Assertion checker for vec_irq_ctrl, attached by bind.
module vic_chk
    import vic_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              msk_wr,
    input logic [MW_W-1:0]   msk_wdata,
    input logic              irq_ack,
    input logic              irq_req,
    input logic              grant_vld,
    input logic [VEC_W-1:0]  grant_vec,
    input logic              grant_ext,
    input logic              inta_o,
    input logic [STAT_W-1:0] status_o
);
    // R13
    grant_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> grant_vld);
    // R13
    no_spurious_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ack && irq_req) |=> !grant_vld);
    // R7
    inta_with_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inta_o |-> (grant_vld && grant_ext));
    // R9
    maskable_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && grant_vec != 16'h0024) |-> !status_o[3]);
    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_wr && msk_wdata[MW_EN]) |=> status_o[2:0] == $past(msk_wdata[2:0]));
    // R10
    r75_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[6]) |-> $past((irq_ack && irq_req) || (msk_wr && msk_wdata[MW_CLR])));
endmodule

bind vec_irq_ctrl vic_chk u_chk (
    .clk(clk), .rst_n(rst_n), .msk_wr(msk_wr), .msk_wdata(msk_wdata),
    .irq_ack(irq_ack), .irq_req(irq_req), .grant_vld(grant_vld),
    .grant_vec(grant_vec), .grant_ext(grant_ext), .inta_o(inta_o),
    .status_o(status_o)
);

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_req = 0, rst75_req = 0, rst65_req = 0, rst55_req = 0, intr_req = 0;
    logic ie_set = 0, ie_clr = 0, msk_wr = 0, irq_ack = 0;
    logic [4:0] msk_wdata = '0;
    logic [2:0] swi_num = '0;
    logic irq_req, grant_vld, grant_ext, inta_o;
    logic [15:0] grant_vec, swi_vec;
    logic [6:0] status_o;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vec_irq_ctrl u_vec_irq_ctrl (.*);

    // Reference model state.
    int m_ie, m_msk, m_p75, m_tp, m_trd, m_r7d, m_vld, m_vec, m_ext, m_inta;

    // Winner index: 0 trap, 1 r7.5, 2 r6.5, 3 r5.5, 4 intr, -1 none.
    function automatic int m_win();
        if (m_tp && trap_req) return 0;
        if (m_ie && !m_msk[2] && m_p75) return 1;
        if (m_ie && !m_msk[1] && rst65_req) return 2;
        if (m_ie && !m_msk[0] && rst55_req) return 3;
        if (m_ie && intr_req) return 4;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ie = 0; m_msk = 7; m_p75 = 0; m_tp = 0; m_trd = 0; m_r7d = 0;
            m_vld = 0; m_vec = 0; m_ext = 0; m_inta = 0;
        end else begin
            int w;
            bit acc;
            w = m_win();
            acc = irq_ack && (w >= 0);
            m_vld = acc;
            m_inta = acc && w == 4;
            if (acc) begin
                case (w)
                    0: m_vec = 'h24;
                    1: m_vec = 'h3C;
                    2: m_vec = 'h34;
                    3: m_vec = 'h2C;
                    default: m_vec = 0;
                endcase
                m_ext = (w == 4);
            end
            if (acc && w > 0) m_ie = 0;
            else if (ie_clr) m_ie = 0;
            else if (ie_set) m_ie = 1;
            if (msk_wr && msk_wdata[3]) m_msk = msk_wdata[2:0];
            if ((acc && w == 1) || (msk_wr && msk_wdata[4])) m_p75 = 0;
            else if (rst75_req && !m_r7d) m_p75 = 1;
            if ((acc && w == 0) || !trap_req) m_tp = 0;
            else if (trap_req && !m_trd) m_tp = 1;
            m_trd = trap_req;
            m_r7d = rst75_req;
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk("R2", "irq_req", 32'(irq_req), 32'(m_win() >= 0));
        chk("R13", "grant_vld", 32'(grant_vld), 32'(m_vld));
        chk("R3", "grant_vec", 32'(grant_vec), 32'(m_vec));
        chk("R7", "grant_ext", 32'(grant_ext), 32'(m_ext));
        chk("R7", "inta_o", 32'(inta_o), 32'(m_inta));
        chk("R6", "masks", 32'(status_o[2:0]), 32'(m_msk));
        chk("R5", "enable", 32'(status_o[3]), 32'(m_ie));
        chk("R10", "r75 latch", 32'(status_o[6]), 32'(m_p75));
        chk("R12", "levels", 32'(status_o[5:4]), 32'({rst65_req, rst55_req}));
    endtask

    // Advance one cycle: clear strobes, apply the caller's settings, then compare.
    task automatic cyc(int ack = 0, int set = 0, int clr = 0, int wr = 0, int wd = 0);
        @(negedge clk);
        irq_ack = ack[0]; ie_set = set[0]; ie_clr = clr[0];
        msk_wr = wr[0]; msk_wdata = wd[4:0];
        #1;
        cmp_all();
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int grants;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1", "status", 32'(status_o), 32'h07);
        chk("R1", "grant_vec", 32'(grant_vec), 0);
        chk("R1", "grant_vld", 32'(grant_vld), 0);
        chk("R1", "inta_o", 32'(inta_o), 0);
        // R8 software restart decode
        for (int x = 0; x < 8; x++) begin
            swi_num = 3'(x);
            #1;
            chk("R8", "swi_vec", 32'(swi_vec), 32'(x * 8));
        end
        // R4 TRAP with enable off and all masks set
        trap_req = 1;
        cyc();
        cyc(1);
        cyc();
        chk("R4", "trap vec", 32'(grant_vec), 32'h24);
        // R11 stuck-high TRAP grants once
        grants = 0;
        for (int i = 0; i < 10; i++) begin
            cyc(1);
            grants += grant_vld;
        end
        chk("R11", "stuck trap grants", 32'(grants), 0);
        trap_req = 0;
        cyc();
        // unmask all, enable
        cyc(0, 1, 0, 1, 5'b01000);
        // R5 set and clear together: clear wins
        cyc(0, 1, 1);
        cyc();
        chk("R5", "clr wins", 32'(status_o[3]), 0);
        cyc(0, 1);
        // R10 one-cycle RST7.5 pulse, acknowledged later
        rst75_req = 1;
        cyc();
        rst75_req = 0;
        repeat (5) cyc();
        chk("R10", "latched", 32'(status_o[6]), 1);
        // R2 higher wins over level lines; R9 enable cleared, set in same cycle lost
        rst65_req = 1; intr_req = 1;
        cyc(1, 1);
        cyc();
        chk("R3", "r75 vec", 32'(grant_vec), 32'h3C);
        chk("R9", "ie cleared", 32'(status_o[3]), 0);
        // R7 INTR grant
        rst65_req = 0;
        cyc(0, 1);
        cyc(1);
        cyc();
        chk("R7", "ext", 32'(grant_ext), 1);
        // R10 clear via mask-write bit 4
        intr_req = 0;
        rst75_req = 1;
        cyc();
        rst75_req = 0;
        cyc();
        cyc(0, 0, 0, 1, 5'b10000);
        cyc();
        chk("R10", "cleared by write", 32'(status_o[6]), 0);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 7) == 0) trap_req = ~trap_req;
            if ($urandom_range(0, 5) == 0) rst75_req = ~rst75_req;
            if ($urandom_range(0, 5) == 0) rst65_req = ~rst65_req;
            if ($urandom_range(0, 5) == 0) rst55_req = ~rst55_req;
            if ($urandom_range(0, 5) == 0) intr_req = ~intr_req;
            cyc(int'($urandom_range(0, 2) == 0), int'($urandom_range(0, 2) == 0),
                int'($urandom_range(0, 9) == 0), int'($urandom_range(0, 7) == 0),
                int'($urandom_range(0, 31)));
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule